// File: doc/BRIEF.md
# DDR Read Capture with Flush Reads

This block sits between a memory controller's command path and the path that returns read data. Commands run at quarter rate: each controller cycle carries one command slot, and one read burst of eight data beats comes back as four beat pairs in a single controller cycle (1:8 serialisation). The block models the strobe-clocked input register behaviourally. The newest pair of every burst stays parked in that register until the strobe toggles again. All earlier pairs go into a soft FIFO that holds two bursts. The FIFO is drained in the system clock domain a fixed, worst-case number of cycles after each read command.

Because the last pair only moves when another burst arrives, the block watches the command stream. On the first idle slot after a real read, it reissues that read unchanged as a flush read. The flush read hits the same open row, so the strobe runs on and pushes the parked pair into the FIFO. Every issued read carries a real/flush tag through a delay line matched to the read latency. Data from flush reads is thrown away at the capture point and never reaches the read port.

Top module: `rdcap_read_capture`

## Requirements
- R1: After reset, phy_valid, phy_dummy, rd_valid, rd_data and overflow are all zero.
- R2: A command presented with cmd_valid high is sampled on a rising edge and appears on the phy outputs after that same edge, with phy_dummy low. The cmd_kind encoding is 0 read, 1 write, 2 activate, 3 precharge.
- R3: If the command issued on the previous edge was a real read and cmd_valid is low, the block issues a flush read on this edge. The flush read has phy_kind 0, phy_dummy high, and the bank and address of that real read.
- R4: One idle stretch produces at most one flush read. A second idle slot right after a flush read issues nothing.
- R5: A new real read re-arms flush insertion, so the next idle slot after it produces another flush read.
- R6: No flush read is issued when the previous command was a write, an activate or a precharge.
- R7: No flush read is issued when bank_busy is high for the bank of the preceding read. Busy bits for other banks have no effect.
- R8: dq_burst holds pair i in bits [i*PAIR_W +: PAIR_W]. It is sampled on the RD_LAT-th edge after the edge that issued the read. Pair 3 stays parked and enters the FIFO only when the next burst is sampled. A real read's four pairs appear together on rd_data, pair 0 lowest, with rd_valid high for one cycle after edge RD_LAT+2 counted from the read's issue edge.
- R9: Data from a flush read never appears on rd_data. Each completed real read gives exactly one rd_valid pulse.
- R10: The FIFO holds 8 pairs. A pair arriving when it is full is dropped and sets overflow, which stays high until reset.
- R11: Back-to-back real reads return in issue order.
- R12: A real read whose final pair is still parked at its drain time produces no rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present in this slot |
| cmd_kind | input | 2 | Command kind: 0 read, 1 write, 2 activate, 3 precharge |
| cmd_bank | input | 3 | Bank address |
| cmd_addr | input | 14 | Row or column address |
| bank_busy | input | 8 | Per-bank pending write or precharge |
| phy_valid | output | 1 | Command issued to the memory |
| phy_kind | output | 2 | Issued command kind |
| phy_bank | output | 3 | Issued bank |
| phy_addr | output | 14 | Issued address |
| phy_dummy | output | 1 | Issued command is a flush read |
| dq_valid | input | 1 | A burst is being captured (strobe activity) |
| dq_burst | input | 64 | Four beat pairs of one burst |
| rd_valid | output | 1 | A full real burst is on rd_data |
| rd_data | output | 64 | Drained burst, pair 0 lowest |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
A single read followed by idle slots shows whether the flush read appears, copies the bank and address, and releases the parked pair at the drain point. Alternating reads and idle slots tell re-arming apart from a flush that fires only once. Back-to-back reads separate in-order delivery from flush handling. A write, or a busy bank, after a read shows that a blocked flush leaves the burst undelivered. Stray strobe bursts with no reads outstanding fill the FIFO to test the overflow flag.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_ACT   = 2'd2,
        CMD_PRE   = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic valid;
        logic dummy;
    } rd_tag_t;

endpackage

// File: rtl/rdcap_dummy_inserter.sv
module rdcap_dummy_inserter
    import rdcap_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BANKS-1:0]  bank_busy,
    output logic              phy_valid,
    output logic [1:0]        phy_kind,
    output logic [BANK_W-1:0] phy_bank,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              phy_dummy
);

    typedef struct packed {
        logic              out_valid;
        cmd_kind_e         out_kind;
        logic [BANK_W-1:0] out_bank;
        logic [ADDR_W-1:0] out_addr;
        logic              out_dummy;
        logic              prev_rd;
    } ins_state_t;

    ins_state_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_dummy = 1'b0;
        s_d.prev_rd   = 1'b0;
        if (cmd_valid) begin
            s_d.out_valid = 1'b1;
            s_d.out_kind  = cmd_kind_e'(cmd_kind);
            s_d.out_bank  = cmd_bank;
            s_d.out_addr  = cmd_addr;
            s_d.prev_rd   = (cmd_kind_e'(cmd_kind) == CMD_READ);
        end else if (s_q.prev_rd && !bank_busy[s_q.out_bank]) begin
            // bank and address still hold the read just issued
            s_d.out_valid = 1'b1;
            s_d.out_kind  = CMD_READ;
            s_d.out_dummy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phy_valid = s_q.out_valid;
    assign phy_kind  = s_q.out_kind;
    assign phy_bank  = s_q.out_bank;
    assign phy_addr  = s_q.out_addr;
    assign phy_dummy = s_q.out_dummy;

    // R3: a flush read copies the real read issued on the edge before
    p_dummy_copies_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out_valid && s_q.out_dummy) |->
            ($past(s_q.out_valid) && $past(s_q.out_kind) == CMD_READ && !$past(s_q.out_dummy)
             && s_q.out_bank == $past(s_q.out_bank) && s_q.out_addr == $past(s_q.out_addr)));

    // R4: never two flush reads in a row
    p_single_dummy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out_valid && s_q.out_dummy) |=> !s_q.out_dummy);

    // R6: nothing but a real read arms a flush read
    p_no_dummy_after_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out_valid && s_q.out_kind != CMD_READ) |=> !s_q.out_dummy);

endmodule

// File: rtl/rdcap_tag_pipe.sv
module rdcap_tag_pipe
    import rdcap_pkg::*;
#(
    parameter int LEN     = 7,
    parameter int CAP_IDX = 4,
    parameter int DRN_IDX = 6
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rd_tag_t in_tag,
    output rd_tag_t cap_tag,
    output rd_tag_t drain_tag
);

    typedef struct packed {
        rd_tag_t [LEN-1:0] stage;
    } pipe_state_t;

    pipe_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.stage = {s_q.stage[LEN-2:0], in_tag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap_tag   = s_q.stage[CAP_IDX];
    assign drain_tag = s_q.stage[DRN_IDX];

endmodule

// File: rtl/rdcap_capture_fifo.sv
module rdcap_capture_fifo
    import rdcap_pkg::*;
#(
    parameter int PAIR_W = 16,
    parameter int PAIRS  = 4,
    localparam int DEPTH   = 2 * PAIRS,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int BURST_W = PAIRS * PAIR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dq_valid,
    input  logic [BURST_W-1:0] dq_burst,
    input  rd_tag_t            cap_tag,
    input  rd_tag_t            drain_tag,
    output logic               rd_valid,
    output logic [BURST_W-1:0] rd_data,
    output logic               overflow
);

    typedef logic [PAIR_W-1:0] pair_t;
    localparam logic [CNT_W-1:0] PAIRS_C = CNT_W'(PAIRS);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        pair_t [DEPTH-1:0]  mem;
        logic [PTR_W-1:0]   wr;
        logic [PTR_W-1:0]   rd;
        logic [CNT_W-1:0]   cnt;
        pair_t              held;
        logic               held_v;
        logic               out_v;
        logic [BURST_W-1:0] out_d;
        logic               ovf;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    always_comb begin
        logic [CNT_W-1:0]   cnt;
        logic [PTR_W-1:0]   wp;
        logic [PTR_W-1:0]   rp;
        logic [BURST_W-1:0] push_v;
        int                 push_n;

        s_d       = s_q;
        s_d.out_v = 1'b0;
        cnt       = s_q.cnt;
        wp        = s_q.wr;
        rp        = s_q.rd;
        push_v    = '0;
        push_n    = 0;

        // drain: a real burst whose four pairs are all in the FIFO
        if (drain_tag.valid && !drain_tag.dummy && s_q.cnt >= PAIRS_C) begin
            for (int i = 0; i < PAIRS; i++) begin
                s_d.out_d[i*PAIR_W +: PAIR_W] = s_q.mem[rp];
                rp = rp + 1'b1;
            end
            s_d.out_v = 1'b1;
            cnt       = cnt - PAIRS_C;
        end

        // capture: parked pair moves on whenever the strobe runs again
        if (dq_valid) begin
            if (cap_tag.valid && cap_tag.dummy) begin
                if (s_q.held_v) begin
                    push_v[PAIR_W-1:0] = s_q.held;
                    push_n             = 1;
                end
                s_d.held_v = 1'b0;
            end else begin
                if (s_q.held_v) begin
                    push_v = {dq_burst[(PAIRS-1)*PAIR_W-1:0], s_q.held};
                    push_n = PAIRS;
                end else begin
                    push_v = {PAIR_W'(0), dq_burst[(PAIRS-1)*PAIR_W-1:0]};
                    push_n = PAIRS - 1;
                end
                s_d.held   = dq_burst[(PAIRS-1)*PAIR_W +: PAIR_W];
                s_d.held_v = 1'b1;
            end
        end

        for (int i = 0; i < PAIRS; i++) begin
            if (i < push_n) begin
                if (cnt < DEPTH_C) begin
                    s_d.mem[wp] = push_v[i*PAIR_W +: PAIR_W];
                    wp          = wp + 1'b1;
                    cnt         = cnt + 1'b1;
                end else begin
                    s_d.ovf = 1'b1;
                end
            end
        end

        s_d.wr  = wp;
        s_d.rd  = rp;
        s_d.cnt = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.out_v;
    assign rd_data  = s_q.out_d;
    assign overflow = s_q.ovf;

    // R10: occupancy never exceeds two bursts
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= DEPTH_C);

    // R10: overflow is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |=> s_q.ovf);

    // R9: a flush-read tag at the drain point never yields data
    p_dummy_not_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_tag.valid && drain_tag.dummy) |=> !s_q.out_v);

    // R12: data leaves only when a whole burst was present
    p_drain_needs_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.out_v |-> ($past(s_q.cnt) >= PAIRS_C));

endmodule

// File: rtl/rdcap_read_capture.sv
module rdcap_read_capture
    import rdcap_pkg::*;
#(
    parameter int BANK_W      = 3,
    parameter int ADDR_W      = 14,
    parameter int PAIR_W      = 16,
    parameter int BURST_BEATS = 8,
    parameter int RD_LAT      = 6,
    localparam int PAIRS   = BURST_BEATS / 2,
    localparam int BANKS   = 1 << BANK_W,
    localparam int BURST_W = PAIRS * PAIR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic [BANK_W-1:0]  cmd_bank,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [BANKS-1:0]   bank_busy,
    output logic               phy_valid,
    output logic [1:0]         phy_kind,
    output logic [BANK_W-1:0]  phy_bank,
    output logic [ADDR_W-1:0]  phy_addr,
    output logic               phy_dummy,
    input  logic               dq_valid,
    input  logic [BURST_W-1:0] dq_burst,
    output logic               rd_valid,
    output logic [BURST_W-1:0] rd_data,
    output logic               overflow
);

    rd_tag_t issue_tag, cap_tag, drain_tag;

    rdcap_dummy_inserter #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .bank_busy (bank_busy),
        .phy_valid (phy_valid),
        .phy_kind  (phy_kind),
        .phy_bank  (phy_bank),
        .phy_addr  (phy_addr),
        .phy_dummy (phy_dummy)
    );

    assign issue_tag.valid = phy_valid && (cmd_kind_e'(phy_kind) == CMD_READ);
    assign issue_tag.dummy = phy_dummy;

    rdcap_tag_pipe #(.LEN(RD_LAT + 1), .CAP_IDX(RD_LAT - 2), .DRN_IDX(RD_LAT)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tag    (issue_tag),
        .cap_tag   (cap_tag),
        .drain_tag (drain_tag)
    );

    rdcap_capture_fifo #(.PAIR_W(PAIR_W), .PAIRS(PAIRS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .dq_valid  (dq_valid),
        .dq_burst  (dq_burst),
        .cap_tag   (cap_tag),
        .drain_tag (drain_tag),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .overflow  (overflow)
    );

endmodule

// File: tb/tb_rdcap_read_capture.sv
module tb_rdcap_read_capture;

    localparam int RD_LAT = 6;
    localparam int PAIRS  = 4;
    localparam int DEPTH  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [2:0]  cmd_bank = 3'd0;
    logic [13:0] cmd_addr = 14'd0;
    logic [7:0]  bank_busy = 8'd0;
    logic        dq_valid = 1'b0;
    logic [63:0] dq_burst = 64'd0;
    logic        phy_valid, phy_dummy, rd_valid, overflow;
    logic [1:0]  phy_kind;
    logic [2:0]  phy_bank;
    logic [13:0] phy_addr;
    logic [63:0] rd_data;

    rdcap_read_capture #(.RD_LAT(RD_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .bank_busy(bank_busy),
        .phy_valid(phy_valid), .phy_kind(phy_kind), .phy_bank(phy_bank),
        .phy_addr(phy_addr), .phy_dummy(phy_dummy), .dq_valid(dq_valid),
        .dq_burst(dq_burst), .rd_valid(rd_valid), .rd_data(rd_data), .overflow(overflow)
    );

    always #5 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int e = 0;
    int burst_ctr = 0;
    int rd_pulses = 0, dummies = 0, last_pulse_e = 0;
    logic [63:0] last_pulse_data = '0;
    bit stray = 1'b0;

    // memory model ring
    bit          mem_v[64];
    logic [11:0] mem_id[64];

    // reference model state
    bit          r_prev_rd, r_pv, r_pd, r_hv, r_rv, r_ovf;
    logic [1:0]  r_pk;
    logic [2:0]  r_pb;
    logic [13:0] r_pa;
    logic [15:0] r_h;
    logic [63:0] r_rd;
    bit          rt_v[64], rt_d[64];
    logic [15:0] q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void rpush(input logic [15:0] v);
        if (q.size() < DEPTH) q.push_back(v);
        else r_ovf = 1'b1;
    endfunction

    function automatic void ref_eval(input int ed);
        if (cmd_valid) begin
            r_pv = 1; r_pk = cmd_kind; r_pb = cmd_bank; r_pa = cmd_addr;
            r_pd = 0; r_prev_rd = (cmd_kind == 2'd0);
        end else if (r_prev_rd && !bank_busy[r_pb]) begin
            r_pv = 1; r_pk = 2'd0; r_pd = 1; r_prev_rd = 0;
        end else begin
            r_pv = 0; r_pd = 0; r_prev_rd = 0;
        end
        rt_v[ed % 64] = r_pv && (r_pk == 2'd0);
        rt_d[ed % 64] = r_pd;
        r_rv = 0;
        if (ed >= RD_LAT + 2 && rt_v[(ed-RD_LAT-2) % 64] && !rt_d[(ed-RD_LAT-2) % 64]
            && q.size() >= PAIRS) begin
            for (int i = 0; i < PAIRS; i++) r_rd[i*16 +: 16] = q.pop_front();
            r_rv = 1;
        end
        if (dq_valid) begin
            if (ed >= RD_LAT && rt_v[(ed-RD_LAT) % 64] && rt_d[(ed-RD_LAT) % 64]) begin
                if (r_hv) rpush(r_h);
                r_hv = 0;
            end else begin
                if (r_hv) rpush(r_h);
                for (int i = 0; i < PAIRS-1; i++) rpush(dq_burst[i*16 +: 16]);
                r_h = dq_burst[(PAIRS-1)*16 +: 16];
                r_hv = 1;
            end
        end
    endfunction

    task automatic prep_dq();
        int n;
        n = e + 1 - RD_LAT;
        dq_valid = stray || (n > 0 && mem_v[n % 64]);
        for (int i = 0; i < PAIRS; i++)
            dq_burst[i*16 +: 16] = {(stray ? 12'hFFF : mem_id[((n % 64) + 64) % 64]), 4'(i)};
    endtask

    task automatic step();
        e++;
        ref_eval(e);
        @(posedge clk);
        #1;
        // per-cycle comparison against the reference model
        chk(phy_valid == r_pv, r_pd ? "R3" : "R2", "phy_valid", 64'(phy_valid), 64'(r_pv));
        if (r_pv) begin
            chk(phy_kind == r_pk, "R2", "phy_kind", 64'(phy_kind), 64'(r_pk));
            chk(phy_bank == r_pb, "R3", "phy_bank", 64'(phy_bank), 64'(r_pb));
            chk(phy_addr == r_pa, "R3", "phy_addr", 64'(phy_addr), 64'(r_pa));
            chk(phy_dummy == r_pd, "R4", "phy_dummy", 64'(phy_dummy), 64'(r_pd));
        end
        chk(rd_valid == r_rv, "R9", "rd_valid", 64'(rd_valid), 64'(r_rv));
        if (r_rv) chk(rd_data == r_rd, "R8", "rd_data", rd_data, r_rd);
        chk(overflow == r_ovf, "R10", "overflow", 64'(overflow), 64'(r_ovf));
        if (rd_valid) begin rd_pulses++; last_pulse_e = e; last_pulse_data = rd_data; end
        if (phy_valid && phy_dummy) dummies++;
        mem_v[e % 64] = phy_valid && (phy_kind == 2'd0);
        if (mem_v[e % 64]) begin mem_id[e % 64] = 12'(burst_ctr); burst_ctr++; end
        prep_dq();
    endtask

    task automatic do_reset();
        rst_n = 0; cmd_valid = 0; bank_busy = 0; stray = 0; dq_valid = 0; dq_burst = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        e = 0; burst_ctr = 0; rd_pulses = 0; dummies = 0;
        r_prev_rd = 0; r_pv = 0; r_pd = 0; r_hv = 0; r_rv = 0; r_ovf = 0;
        r_pk = 0; r_pb = 0; r_pa = 0; r_h = 0; r_rd = 0;
        q.delete();
        for (int i = 0; i < 64; i++) begin rt_v[i] = 0; rt_d[i] = 0; mem_v[i] = 0; mem_id[i] = 0; end
    endtask

    task automatic issue(input logic [1:0] k, input logic [2:0] b, input logic [13:0] a);
        cmd_valid = 1; cmd_kind = k; cmd_bank = b; cmd_addr = a;
        step();
        cmd_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(phy_valid == 0 && phy_dummy == 0, "R1", "phy after reset", {phy_valid, phy_dummy}, 0);
        chk(rd_valid == 0 && rd_data == 0, "R1", "rd after reset", rd_data, 0);
        chk(overflow == 0, "R1", "overflow after reset", 64'(overflow), 0);

        // single read then idle: R2 R3 R4 R8 R9
        issue(2'd0, 3'd2, 14'h123);
        chk(phy_valid && phy_kind == 0 && !phy_dummy, "R2", "real read issued",
            {phy_valid, phy_kind, phy_dummy}, 64'b1000);
        step();
        chk(phy_valid && phy_dummy && phy_bank == 2 && phy_addr == 14'h123, "R3", "flush read copy",
            {phy_dummy, phy_bank, phy_addr}, {1'b1, 3'd2, 14'h123});
        step();
        chk(!phy_valid, "R4", "second idle slot silent", 64'(phy_valid), 0);
        idle(10);
        chk(rd_pulses == 1, "R9", "pulses for one read", 64'(rd_pulses), 1);
        chk(last_pulse_e == 1 + RD_LAT + 2, "R8", "drain edge", 64'(last_pulse_e), 64'(1 + RD_LAT + 2));
        chk(last_pulse_data == 64'h0003_0002_0001_0000, "R8", "burst data",
            last_pulse_data, 64'h0003_0002_0001_0000);

        // re-arm: R5
        dummies = 0;
        issue(2'd0, 3'd1, 14'h7);
        step();
        issue(2'd0, 3'd4, 14'h9);
        step();
        chk(dummies == 2, "R5", "flush per idle stretch", 64'(dummies), 2);
        idle(10);

        // back-to-back reads: R11
        rd_pulses = 0;
        issue(2'd0, 3'd0, 14'h10);
        issue(2'd0, 3'd1, 14'h11);
        issue(2'd0, 3'd2, 14'h12);
        idle(12);
        chk(rd_pulses == 3, "R11", "three bursts in order", 64'(rd_pulses), 3);

        // write after read: R6 R12
        do_reset();
        issue(2'd0, 3'd3, 14'h20);
        issue(2'd1, 3'd3, 14'h20);
        step();
        chk(!phy_valid && !phy_dummy, "R6", "no flush after write", {phy_valid, phy_dummy}, 0);
        idle(10);
        chk(dummies == 0, "R6", "flush count", 64'(dummies), 0);
        chk(rd_pulses == 0, "R12", "parked burst not drained", 64'(rd_pulses), 0);

        // busy bank: R7 R12
        do_reset();
        issue(2'd0, 3'd5, 14'h30);
        bank_busy = 8'h20;
        step();
        chk(!phy_valid, "R7", "busy bank blocks flush", 64'(phy_valid), 0);
        bank_busy = 8'h00;
        step();
        chk(!phy_valid, "R7", "no late flush", 64'(phy_valid), 0);
        idle(10);
        chk(rd_pulses == 0, "R12", "blocked flush leaves burst", 64'(rd_pulses), 0);
        do_reset();
        issue(2'd0, 3'd5, 14'h31);
        bank_busy = 8'h08;
        step();
        chk(phy_valid && phy_dummy, "R7", "other bank busy ignored", {phy_valid, phy_dummy}, 64'b11);
        bank_busy = 8'h00;
        idle(10);
        chk(rd_pulses == 1, "R9", "one pulse after flush", 64'(rd_pulses), 1);

        // stray bursts fill the FIFO: R10
        do_reset();
        stray = 1;
        prep_dq();
        idle(2);
        chk(overflow == 0, "R10", "seven pairs fit", 64'(overflow), 0);
        step();
        chk(overflow == 1, "R10", "overflow on full", 64'(overflow), 1);
        stray = 0;
        prep_dq();
        idle(3);
        chk(overflow == 1, "R10", "overflow sticky", 64'(overflow), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule